// File: doc/BRIEF.md
# Dual-Channel Pixel Line Merger

This block joins two pixel streams, channel A and channel B, into one output stream for each scan line. Each channel writes whole pixels into its own queue, one pixel per cycle that its valid strobe is high. A marker bit that travels with the first pixel of a line opens that line. Channel A's marker opens the output line. Channel B's marker only lines up channel B's data with channel A.

A timing generator downstream pulls pixels with a one-cycle read request. Each request yields exactly one pixel, two cycles later. The order of the pixels is set at run time. In interleave order, pixels come alternately from A and B, starting with A. In split order, the left part of the line comes from A and the right part comes from B. B's pixels wait in their queue until A's part has been sent.

When the chosen queue holds nothing, the block sends an all-zero pixel rather than stalling. It also raises a sticky flag. The pixel width is a parameter, 18 or 24 bits.

Top module: `pix_line_merge`

## Requirements
- R1: With `cfg_mode` = 0 (interleave), the pixels of a line are output in the order A, B, A, B, and so on, starting with channel A after channel A's line start.
- R2: With `cfg_mode` = 1 (split), the first `cfg_len_a` pixels of a line come from channel A and all later pixels come from channel B.
- R3: In split order, if channel A's queue is empty when a pixel is due from A, output moves to channel B for the rest of the line, even before `cfg_len_a` pixels have been sent.
- R4: A request whose chosen queue is empty returns an all-zero pixel and sets `underrun`. The flag stays set until a one-cycle `underrun_clr` strobe clears it. A new underrun in the same cycle as the strobe wins over the strobe.
- R5: Each `rd_req` cycle produces exactly one cycle of `out_valid` with one pixel, two clock cycles later.
- R6: `cfg_err` is high one cycle after `cfg_mode` = 1 and `cfg_len_b` = 0 hold together, and is low one cycle after any other setting.
- R7: A channel A pixel with `a_sol` set discards the pixels left in A's queue and restarts the output order. Interleave order begins again with A, and split order begins again with the left part.
- R8: A channel B pixel with `b_sol` set discards the pixels left in B's queue. The marked pixel becomes the first B pixel of the line.
- R9: A pixel that arrives at a full queue is dropped and sets that channel's sticky overflow flag (`ovf_a` or `ovf_b`). The pixels already queued are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 1 | 0 = interleave A/B, 1 = split left A / right B |
| cfg_len_a | input | LEN_W | Channel A pixels per line |
| cfg_len_b | input | LEN_W | Channel B pixels per line |
| a_valid | input | 1 | Channel A pixel strobe |
| a_sol | input | 1 | Channel A line start, qualified by a_valid |
| a_data | input | PIX_W | Channel A pixel |
| b_valid | input | 1 | Channel B pixel strobe |
| b_sol | input | 1 | Channel B line start, qualified by b_valid |
| b_data | input | PIX_W | Channel B pixel |
| rd_req | input | 1 | Request for one output pixel |
| underrun_clr | input | 1 | Write-one-to-clear strobe for underrun |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | PIX_W | Output pixel |
| underrun | output | 1 | Sticky: a zero pixel was substituted |
| ovf_a | output | 1 | Sticky: channel A pixel dropped at a full queue |
| ovf_b | output | 1 | Sticky: channel B pixel dropped at a full queue |
| cfg_err | output | 1 | Split order selected with a zero channel B length |

## Verification
The bench builds the block with an 18-bit pixel, eight-entry queues and an 8-bit length field. The narrow pixel exercises the 18-bit variant. It also shows that a zero substitute clears every bit of that width. The shallow queues make an overflow reachable with nine writes. The short lines let interleave order, split order, the early switch to B and a mid-line restart each appear within a few requests.

// File: rtl/pix_merge_pkg.sv
package pix_merge_pkg;

  typedef enum logic {
    MODE_INTERLEAVE = 1'b0,
    MODE_SPLIT      = 1'b1
  } merge_mode_e;

endpackage

// File: rtl/pix_fifo.sv
module pix_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         ovf
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign do_wr = wr_en && (flush || !full);
  assign do_rd = rd_en && !empty && !flush;

  // storage without reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else if (flush) begin
      rd_ptr <= wr_ptr;
      wr_ptr <= do_wr ? ptr_inc(wr_ptr) : wr_ptr;
      count  <= do_wr ? CW'(1) : '0;
    end else begin
      if (do_wr) wr_ptr <= ptr_inc(wr_ptr);
      if (do_rd) rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CW'(do_wr) - CW'(do_rd);
      if (wr_en && full) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/pix_merge_sel.sv
module pix_merge_sel
  import pix_merge_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic [LEN_W-1:0] len_a,
  input  logic             a_empty,
  input  logic             b_empty,
  input  logic             a_flush,
  input  logic             b_flush,
  input  logic             rd_req,
  output logic             pop_a,
  output logic             pop_b,
  output logic             pick_b,
  output logic             take_zero
);

  logic             odd_slot;
  logic             right_phase;
  logic [LEN_W-1:0] a_sent;
  logic             a_done;
  logic             avail;

  assign a_done = (a_sent >= len_a);

  always_comb begin
    if (merge_mode_e'(mode) == MODE_SPLIT)
      pick_b = right_phase || a_done || a_empty;
    else
      pick_b = odd_slot;
    avail     = pick_b ? (!b_empty && !b_flush) : (!a_empty && !a_flush);
    take_zero = rd_req && (a_flush || !avail);
    pop_a     = rd_req && !a_flush && !pick_b && avail;
    pop_b     = rd_req && !a_flush &&  pick_b && avail;
  end

  always_ff @(posedge clk) begin
    if (rst || a_flush) begin
      odd_slot    <= 1'b0;
      right_phase <= 1'b0;
      a_sent      <= '0;
    end else if (rd_req) begin
      odd_slot <= ~odd_slot;
      if (merge_mode_e'(mode) == MODE_SPLIT && pick_b) right_phase <= 1'b1;
      if (pop_a) a_sent <= a_sent + 1'b1;
    end
  end

endmodule

// File: rtl/pix_line_merge.sv
module pix_line_merge
  import pix_merge_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int DEPTH = 64,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_mode,
  input  logic [LEN_W-1:0] cfg_len_a,
  input  logic [LEN_W-1:0] cfg_len_b,
  input  logic             a_valid,
  input  logic             a_sol,
  input  logic [PIX_W-1:0] a_data,
  input  logic             b_valid,
  input  logic             b_sol,
  input  logic [PIX_W-1:0] b_data,
  input  logic             rd_req,
  input  logic             underrun_clr,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             underrun,
  output logic             ovf_a,
  output logic             ovf_b,
  output logic             cfg_err
);

  logic             a_flush, b_flush;
  logic             a_empty, b_empty, a_full, b_full;
  logic             pop_a, pop_b, pick_b, take_zero;
  logic [PIX_W-1:0] a_q, b_q;
  logic             s1_valid, s1_zero, s1_b;

  assign a_flush = a_valid && a_sol;
  assign b_flush = b_valid && b_sol;

  pix_fifo #(.W(PIX_W), .DEPTH(DEPTH)) fifo_a_i (
    .clk(clk), .rst(rst), .flush(a_flush), .wr_en(a_valid), .wr_data(a_data),
    .rd_en(pop_a), .rd_data(a_q), .empty(a_empty), .full(a_full), .ovf(ovf_a)
  );

  pix_fifo #(.W(PIX_W), .DEPTH(DEPTH)) fifo_b_i (
    .clk(clk), .rst(rst), .flush(b_flush), .wr_en(b_valid), .wr_data(b_data),
    .rd_en(pop_b), .rd_data(b_q), .empty(b_empty), .full(b_full), .ovf(ovf_b)
  );

  pix_merge_sel #(.LEN_W(LEN_W)) sel_i (
    .clk(clk), .rst(rst), .mode(cfg_mode), .len_a(cfg_len_a),
    .a_empty(a_empty), .b_empty(b_empty), .a_flush(a_flush), .b_flush(b_flush),
    .rd_req(rd_req), .pop_a(pop_a), .pop_b(pop_b), .pick_b(pick_b),
    .take_zero(take_zero)
  );

  // stage 1: queue read registers load, selection remembered
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_zero  <= 1'b0;
      s1_b     <= 1'b0;
    end else begin
      s1_valid <= rd_req;
      s1_zero  <= take_zero;
      s1_b     <= pick_b;
    end
  end

  // stage 2: registered output pixel
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (!s1_valid || s1_zero) out_data <= '0;
      else                      out_data <= s1_b ? b_q : a_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      underrun <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      if (take_zero)         underrun <= 1'b1;
      else if (underrun_clr) underrun <= 1'b0;
      cfg_err <= (merge_mode_e'(cfg_mode) == MODE_SPLIT) && (cfg_len_b == '0);
    end
  end

endmodule

// File: rtl/pix_line_merge_chk.sv
module pix_line_merge_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_mode,
  input logic [LEN_W-1:0] cfg_len_b,
  input logic             rd_req,
  input logic             underrun_clr,
  input logic             out_valid,
  input logic             underrun,
  input logic             ovf_a,
  input logic             ovf_b,
  input logic             cfg_err
);

  AST_REQ_GIVES_PIXEL: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ##2 out_valid); // R5
  AST_NO_SPURIOUS_PIXEL: assert property (@(posedge clk) disable iff (rst)
    !rd_req |-> ##2 !out_valid); // R5
  AST_CFG_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && cfg_len_b == '0) |=> cfg_err); // R6
  AST_CFG_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(cfg_mode && cfg_len_b == '0) |=> !cfg_err); // R6
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (underrun && !underrun_clr) |=> underrun); // R4
  AST_OVF_A_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_a |=> ovf_a); // R9
  AST_OVF_B_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_b |=> ovf_b); // R9

endmodule

bind pix_line_merge pix_line_merge_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_len_b(cfg_len_b),
  .rd_req(rd_req), .underrun_clr(underrun_clr), .out_valid(out_valid),
  .underrun(underrun), .ovf_a(ovf_a), .ovf_b(ovf_b), .cfg_err(cfg_err)
);

// File: tb/pix_line_merge_tb_top.sv
module pix_line_merge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 18;
  localparam int DEPTH = 8;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_mode = 1'b0;
  logic [LEN_W-1:0] cfg_len_a = 8'd4;
  logic [LEN_W-1:0] cfg_len_b = 8'd4;
  logic             a_valid = 1'b0, a_sol = 1'b0;
  logic [PIX_W-1:0] a_data = '0;
  logic             b_valid = 1'b0, b_sol = 1'b0;
  logic [PIX_W-1:0] b_data = '0;
  logic             rd_req = 1'b0;
  logic             underrun_clr = 1'b0;
  logic             out_valid;
  logic [PIX_W-1:0] out_data;
  logic             underrun, ovf_a, ovf_b, cfg_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_line_merge #(.PIX_W(PIX_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_len_a(cfg_len_a),
    .cfg_len_b(cfg_len_b), .a_valid(a_valid), .a_sol(a_sol), .a_data(a_data),
    .b_valid(b_valid), .b_sol(b_sol), .b_data(b_data), .rd_req(rd_req),
    .underrun_clr(underrun_clr), .out_valid(out_valid), .out_data(out_data),
    .underrun(underrun), .ovf_a(ovf_a), .ovf_b(ovf_b), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_a(input logic [PIX_W-1:0] d, input logic sol);
    @(negedge clk); a_valid = 1'b1; a_sol = sol; a_data = d;
    @(negedge clk); a_valid = 1'b0; a_sol = 1'b0;
  endtask

  task automatic push_b(input logic [PIX_W-1:0] d, input logic sol);
    @(negedge clk); b_valid = 1'b1; b_sol = sol; b_data = d;
    @(negedge clk); b_valid = 1'b0; b_sol = 1'b0;
  endtask

  task automatic line_a(input logic [PIX_W-1:0] base, input int n);
    for (int i = 0; i < n; i++) push_a(base + PIX_W'(i), i == 0);
  endtask

  task automatic line_b(input logic [PIX_W-1:0] base, input int n);
    for (int i = 0; i < n; i++) push_b(base + PIX_W'(i), i == 0);
  endtask

  task automatic read_one(input string req, input logic [PIX_W-1:0] exp);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " pixel"}, 32'(out_data), 32'(exp));
  endtask

  task automatic t_reset;
    chk("reset out_valid", 32'(out_valid), 0);
    chk("reset underrun", 32'(underrun), 0);
    chk("reset ovf", {30'd0, ovf_a, ovf_b}, 0);
    chk("reset cfg_err", 32'(cfg_err), 0);
  endtask

  task automatic t_latency; // R5
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk("R5 one cycle after", 32'(out_valid), 0);
    @(negedge clk);
    chk("R5 two cycles after", 32'(out_valid), 1);
    @(negedge clk);
    chk("R5 single pulse", 32'(out_valid), 0);
    @(negedge clk); underrun_clr = 1'b1;
    @(negedge clk); underrun_clr = 1'b0;
  endtask

  task automatic t_interleave; // R1
    cfg_mode = 1'b0;
    line_b(18'h0B000, 3);
    line_a(18'h0A000, 3);
    for (int i = 0; i < 3; i++) begin
      read_one("R1 A slot", 18'h0A000 + PIX_W'(i));
      read_one("R1 B slot", 18'h0B000 + PIX_W'(i));
    end
    chk("R1 no underrun", 32'(underrun), 0);
  endtask

  task automatic t_split; // R2
    cfg_mode = 1'b1; cfg_len_a = 8'd3;
    line_a(18'h0A010, 5);
    line_b(18'h0B010, 2);
    for (int i = 0; i < 3; i++) read_one("R2 left", 18'h0A010 + PIX_W'(i));
    for (int i = 0; i < 2; i++) read_one("R2 right", 18'h0B010 + PIX_W'(i));
  endtask

  task automatic t_split_early; // R3
    cfg_mode = 1'b1; cfg_len_a = 8'd5;
    line_a(18'h0A020, 2);
    line_b(18'h0B020, 2);
    read_one("R3 left", 18'h0A020);
    read_one("R3 left", 18'h0A021);
    read_one("R3 switch", 18'h0B020);
    read_one("R3 right", 18'h0B021);
    chk("R3 no underrun", 32'(underrun), 0);
  endtask

  task automatic t_underrun; // R4
    cfg_mode = 1'b0;
    line_a(18'h0A030, 1);
    line_b(18'h0B030, 1);
    read_one("R4 A", 18'h0A030);
    read_one("R4 B", 18'h0B030);
    chk("R4 flag before", 32'(underrun), 0);
    read_one("R4 zero pixel", '0);
    chk("R4 flag set", 32'(underrun), 1);
    read_one("R4 zero pixel B", '0);
    @(negedge clk); underrun_clr = 1'b1;
    @(negedge clk); underrun_clr = 1'b0;
    chk("R4 flag cleared", 32'(underrun), 0);
  endtask

  task automatic t_resync; // R7 R8
    cfg_mode = 1'b0;
    line_a(18'h0A040, 3);
    line_b(18'h0B040, 3);
    read_one("R7 old A", 18'h0A040);
    read_one("R8 old B", 18'h0B040);
    line_a(18'h0A140, 2);
    line_b(18'h0B140, 2);
    read_one("R7 new line A first", 18'h0A140);
    read_one("R8 new line B first", 18'h0B140);
    read_one("R7 leftover A dropped", 18'h0A141);
    read_one("R8 leftover B dropped", 18'h0B141);
  endtask

  task automatic t_overflow; // R9
    cfg_mode = 1'b0;
    chk("R9 ovf_b before", 32'(ovf_b), 0);
    line_b(18'h0B200, DEPTH + 1);
    chk("R9 ovf_b set", 32'(ovf_b), 1);
    chk("R9 ovf_a clear", 32'(ovf_a), 0);
    line_a(18'h0A200, 1);
    read_one("R9 A", 18'h0A200);
    read_one("R9 B head kept", 18'h0B200);
    chk("R9 ovf_b sticky", 32'(ovf_b), 1);
  endtask

  task automatic t_cfg; // R6
    cfg_mode = 1'b1; cfg_len_b = 8'd0;
    @(negedge clk);
    chk("R6 split zero length", 32'(cfg_err), 1);
    cfg_len_b = 8'd1;
    @(negedge clk);
    chk("R6 split length one", 32'(cfg_err), 0);
    cfg_mode = 1'b0; cfg_len_b = 8'd0;
    @(negedge clk);
    chk("R6 interleave zero length", 32'(cfg_err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_interleave();
    t_split();
    t_split_early();
    t_underrun();
    t_resync();
    t_overflow();
    t_cfg();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule